// File: doc/BRIEF.md
# Windowed register file controller

This block is a register file for a processor whose procedures each get a private set of registers. It holds a small bank of global registers and a larger windowed bank. The windowed bank is treated as a ring of overlapping windows. A 5-bit logical register number is translated to a physical register through the current window pointer. Because adjacent windows share one group of registers, a caller's outgoing-argument registers are the callee's incoming-argument registers, so arguments are passed without copying.

A call request advances the current window pointer and a return request retreats it. A saved window pointer marks the boundary between the windows that are resident and the ones that have been spilled to memory.

A call that would run into that boundary, or a return that would step onto it, does not move the pointer. Instead it raises an overflow or underflow trap and waits. The spill or fill itself is done outside the block. A handler acknowledges it with a one-cycle pulse, and on that pulse the block moves the saved window pointer and completes the stalled call or return.

Top module: `win_regfile`

## Requirements
- R1: After reset the current window pointer is 0, the saved window pointer is NWIN-1 (7), both trap outputs are low, and every register reads as zero.
- R2: Logical registers 0–7 select physical registers 0–7 in every window.
- R3: In window w, logical 8+k (temporary), 16+k (local) and 24+k (parameter) select physical 8+((104+k−16w) mod 128), 8+((112+k−16w) mod 128) and 8+((120+k−16w) mod 128) respectively, for k in 0–7.
- R4: The temporary k of window w is the same storage as the parameter k of window (w+1) mod 8. This includes a write issued in the same cycle as a call: it lands in the old window and reads back through the new window's parameter register.
- R5: Both read ports are combinational. A write is stored at the clock edge and is not visible before it.
- R6: A call whose target window (cwp+1 mod 8) differs from the saved window pointer sets cwp to that target on the next edge.
- R7: A return whose target window (cwp−1 mod 8) differs from the saved window pointer sets cwp to that target on the next edge.
- R8: A call whose target equals the saved window pointer leaves cwp unchanged and raises the overflow trap on the next edge. The trap holds until spill_done_i. The edge that samples spill_done_i adds 1 to swp, adds 1 to cwp and clears the trap.
- R9: A return whose target equals the saved window pointer leaves cwp unchanged and raises the underflow trap on the next edge. The trap holds until fill_done_i. The edge that samples fill_done_i subtracts 1 from swp, subtracts 1 from cwp and clears the trap.
- R10: While a trap is pending, call and return requests and the non-matching acknowledge are ignored. With no trap pending, both acknowledges are ignored.
- R11: A call and a return asserted together, with no trap pending, change nothing.
- R12: The two traps are never high together, cwp never equals swp, and cwp moves by at most one window per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Procedure call request (one cycle) |
| ret_i | input | 1 | Procedure return request (one cycle) |
| spill_done_i | input | 1 | Acknowledge that the oldest window was saved |
| fill_done_i | input | 1 | Acknowledge that the missing window was reloaded |
| ra_addr_i | input | 5 | Read port A logical register |
| rb_addr_i | input | 5 | Read port B logical register |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write logical register |
| wr_data_i | input | 32 | Write data |
| ra_data_o | output | 32 | Read port A data |
| rb_data_o | output | 32 | Read port B data |
| ovf_trap_o | output | 1 | Window overflow trap pending |
| unf_trap_o | output | 1 | Window underflow trap pending |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved window pointer |

## Verification
A register write and a window change can fall in the same cycle. That case also tests whether the write address is translated with the old pointer or the new one. The bench issues a temporary-register write together with a call. One cycle later it reads the new window's matching parameter register and expects the written value there.

Acknowledge pulses are also driven while the opposite trap is pending, or while no trap is pending. For those cases the bench compares both pointers and both trap outputs with a model kept in the bench.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    // Register group selected by the upper two bits of a logical number
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_TEMP   = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_PARAM  = 2'd3
    } wrf_grp_e;

endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter  int GSZ  = 8,
    parameter  int NWIN = 8,
    localparam int GW   = $clog2(GSZ),
    localparam int LAW  = GW + 2,
    localparam int WPW  = $clog2(NWIN),
    localparam int TOTW = 2 * GSZ * NWIN,
    localparam int PAW  = $clog2(GSZ + TOTW)
) (
    input  logic [WPW-1:0] cwp_i,
    input  logic [LAW-1:0] lreg_i,
    output logic [PAW-1:0] phys_o
);

    wrf_grp_e     grp;
    logic [GW-1:0] idx;
    int           ofs;

    always_comb begin
        grp = wrf_grp_e'(lreg_i[LAW-1:GW]);
        idx = lreg_i[GW-1:0];
        // windowed offset, kept non-negative before the modulo
        ofs = TOTW - 3 * GSZ + (int'(lreg_i[LAW-1:GW]) - 1) * GSZ + int'(idx)
              + TOTW - 2 * GSZ * int'(cwp_i);
        if (grp == GRP_GLOBAL) begin
            phys_o = PAW'(idx);
        end else begin
            phys_o = PAW'(GSZ + (ofs % TOTW));
        end
    end

endmodule

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl #(
    parameter  int NWIN = 8,
    localparam int WPW  = $clog2(NWIN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           call_i,
    input  logic           ret_i,
    input  logic           spill_done_i,
    input  logic           fill_done_i,
    output logic [WPW-1:0] cwp_o,
    output logic [WPW-1:0] swp_o,
    output logic           ovf_o,
    output logic           unf_o
);

    typedef struct packed {
        logic [WPW-1:0] cwp;
        logic [WPW-1:0] swp;
        logic           ovf;
        logic           unf;
    } ctl_t;

    ctl_t           s_d, s_q;
    logic [WPW-1:0] nxt_w, prv_w;

    always_comb begin
        s_d   = s_q;
        nxt_w = s_q.cwp + WPW'(1);
        prv_w = s_q.cwp - WPW'(1);
        if (s_q.ovf) begin
            if (spill_done_i) begin
                s_d.swp = s_q.swp + WPW'(1);
                s_d.cwp = nxt_w;
                s_d.ovf = 1'b0;
            end
        end else if (s_q.unf) begin
            if (fill_done_i) begin
                s_d.swp = s_q.swp - WPW'(1);
                s_d.cwp = prv_w;
                s_d.unf = 1'b0;
            end
        end else if (call_i && !ret_i) begin
            if (nxt_w == s_q.swp) s_d.ovf = 1'b1;
            else                  s_d.cwp = nxt_w;
        end else if (ret_i && !call_i) begin
            if (prv_w == s_q.swp) s_d.unf = 1'b1;
            else                  s_d.cwp = prv_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cwp <= '0;
            s_q.swp <= WPW'(NWIN - 1);
            s_q.ovf <= 1'b0;
            s_q.unf <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cwp_o = s_q.cwp;
    assign swp_o = s_q.swp;
    assign ovf_o = s_q.ovf;
    assign unf_o = s_q.unf;

endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter  int DW    = 32,
    parameter  int NPHYS = 136,
    localparam int PAW   = $clog2(NPHYS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we_i,
    input  logic [PAW-1:0] waddr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [PAW-1:0] raddr_a_i,
    input  logic [PAW-1:0] raddr_b_i,
    output logic [DW-1:0]  rdata_a_o,
    output logic [DW-1:0]  rdata_b_o
);

    typedef struct packed {
        logic [NPHYS-1:0][DW-1:0] mem;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) s_d.mem[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata_a_o = s_q.mem[raddr_a_i];
    assign rdata_b_o = s_q.mem[raddr_b_i];

endmodule

// File: rtl/win_regfile.sv
module win_regfile #(
    parameter  int DW    = 32,
    parameter  int GSZ   = 8,
    parameter  int NWIN  = 8,
    localparam int LAW   = $clog2(GSZ) + 2,
    localparam int WPW   = $clog2(NWIN),
    localparam int NPHYS = GSZ + 2 * GSZ * NWIN,
    localparam int PAW   = $clog2(NPHYS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           call_i,
    input  logic           ret_i,
    input  logic           spill_done_i,
    input  logic           fill_done_i,
    input  logic [LAW-1:0] ra_addr_i,
    input  logic [LAW-1:0] rb_addr_i,
    input  logic           wr_en_i,
    input  logic [LAW-1:0] wr_addr_i,
    input  logic [DW-1:0]  wr_data_i,
    output logic [DW-1:0]  ra_data_o,
    output logic [DW-1:0]  rb_data_o,
    output logic           ovf_trap_o,
    output logic           unf_trap_o,
    output logic [WPW-1:0] cwp_o,
    output logic [WPW-1:0] swp_o
);

    localparam int NPORT = 3;

    logic [WPW-1:0] cwp;
    logic [LAW-1:0] lg [NPORT];
    logic [PAW-1:0] ph [NPORT];

    assign lg[0] = ra_addr_i;
    assign lg[1] = rb_addr_i;
    assign lg[2] = wr_addr_i;

    wrf_window_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .call_i       (call_i),
        .ret_i        (ret_i),
        .spill_done_i (spill_done_i),
        .fill_done_i  (fill_done_i),
        .cwp_o        (cwp),
        .swp_o        (swp_o),
        .ovf_o        (ovf_trap_o),
        .unf_o        (unf_trap_o)
    );

    // one translator per port, all using the pre-update window pointer
    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wrf_addr_map #(.GSZ(GSZ), .NWIN(NWIN)) u_map (
            .cwp_i  (cwp),
            .lreg_i (lg[p]),
            .phys_o (ph[p])
        );
    end

    wrf_storage #(.DW(DW), .NPHYS(NPHYS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_en_i),
        .waddr_i   (ph[2]),
        .wdata_i   (wr_data_i),
        .raddr_a_i (ph[0]),
        .raddr_b_i (ph[1]),
        .rdata_a_o (ra_data_o),
        .rdata_b_o (rb_data_o)
    );

    assign cwp_o = cwp;

endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
    parameter  int NWIN = 8,
    localparam int WPW  = $clog2(NWIN)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           call_i,
    input logic           spill_done_i,
    input logic           fill_done_i,
    input logic           ovf_trap_o,
    input logic           unf_trap_o,
    input logic [WPW-1:0] cwp_o,
    input logic [WPW-1:0] swp_o
);

    // R12
    traps_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_trap_o && unf_trap_o));

    // R12
    cwp_ne_swp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cwp_o != swp_o);

    // R12
    cwp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cwp_o == $past(cwp_o)) || (cwp_o == WPW'($past(cwp_o) + 1'b1))
        || (cwp_o == WPW'($past(cwp_o) - 1'b1)));

    // R8
    ovf_from_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_trap_o) |-> $past(call_i));

    // R8
    spill_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap_o && spill_done_i |=> !ovf_trap_o && (swp_o == WPW'($past(swp_o) + 1'b1)));

    // R9
    fill_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap_o && fill_done_i |=> !unf_trap_o && (swp_o == WPW'($past(swp_o) - 1'b1)));

    // R10
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap_o && !spill_done_i |=> ovf_trap_o && $stable(cwp_o) && $stable(swp_o));

    // R10
    swp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_trap_o && !unf_trap_o |=> $stable(swp_o));

endmodule

bind win_regfile win_regfile_chk #(.NWIN(NWIN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .call_i       (call_i),
    .spill_done_i (spill_done_i),
    .fill_done_i  (fill_done_i),
    .ovf_trap_o   (ovf_trap_o),
    .unf_trap_o   (unf_trap_o),
    .cwp_o        (cwp_o),
    .swp_o        (swp_o)
);

// File: tb/win_regfile_bench.sv
`timescale 1ns/1ps
module win_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 0, ret_i = 0, spill_done_i = 0, fill_done_i = 0;
    logic [4:0]  ra_addr_i = 0, rb_addr_i = 0, wr_addr_i = 0;
    logic        wr_en_i = 0;
    logic [31:0] wr_data_i = 0;
    logic [31:0] ra_data_o, rb_data_o;
    logic        ovf_trap_o, unf_trap_o;
    logic [2:0]  cwp_o, swp_o;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [31:0] model [136];
    int mcwp, mswp;

    always #4 clk = ~clk;

    win_regfile u_win_regfile (.*);

    function automatic int phys(int l, int w);
        if (l < 8) return l;
        return 8 + ((104 + 8 * ((l - 8) / 8) + (l % 8) - 16 * w + 256) % 128);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_state(string req, logic eo, logic eu);
        chk(req, 32'(cwp_o), 32'(mcwp));
        chk(req, 32'(swp_o), 32'(mswp));
        chk(req, 32'(ovf_trap_o), 32'(eo));
        chk(req, 32'(unf_trap_o), 32'(eu));
        chk("R12", 32'(ovf_trap_o && unf_trap_o), 32'd0);
    endtask

    task automatic pulse(logic c, logic r, logic s, logic f);
        @(negedge clk);
        call_i = c; ret_i = r; spill_done_i = s; fill_done_i = f;
        @(negedge clk);
        call_i = 0; ret_i = 0; spill_done_i = 0; fill_done_i = 0;
    endtask

    task automatic wr(int l, logic [31:0] d, logic c);
        @(negedge clk);
        wr_en_i = 1; wr_addr_i = 5'(l); wr_data_i = d; call_i = c;
        model[phys(l, mcwp)] = d;
        @(negedge clk);
        wr_en_i = 0; call_i = 0;
    endtask

    task automatic read_all(string req);
        for (int l = 0; l < 32; l++) begin
            ra_addr_i = 5'(l);
            rb_addr_i = 5'(31 - l);
            #1;
            chk(req, ra_data_o, model[phys(l, mcwp)]);
            chk(req, rb_data_o, model[phys(31 - l, mcwp)]);
        end
    endtask

    task automatic fill_window(int w);
        for (int l = 0; l < 32; l++)
            wr(l, 32'h5A00_0000 ^ 32'(w * 256 + l), 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 136; i++) model[i] = '0;
        mcwp = 0; mswp = 7;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        chk_state("R1", 0, 0);
        read_all("R1");

        // R2 R3 R6: write every register in windows 0..6, check all mappings
        for (int w = 0; w < 7; w++) begin
            fill_window(w);
            read_all("R3");
            if (w < 6) begin
                pulse(1, 0, 0, 0); mcwp++;
                chk_state("R6", 0, 0);
                read_all("R2");
            end
        end

        // R8 overflow at cwp=6, swp=7
        pulse(1, 0, 0, 0);
        chk_state("R8", 1, 0);
        // R10 ignored while pending
        pulse(1, 0, 0, 0); chk_state("R10", 1, 0);
        pulse(0, 1, 0, 0); chk_state("R10", 1, 0);
        pulse(0, 0, 0, 1); chk_state("R10", 1, 0);
        read_all("R5");
        pulse(0, 0, 1, 0); mcwp = 7; mswp = 0;
        chk_state("R8", 0, 0);

        // R4 wrap: window 7 temporaries alias window 0 parameters
        fill_window(7);
        read_all("R4");

        // R7 returns down to window 1
        while (mcwp > 1) begin
            pulse(0, 1, 0, 0); mcwp--;
            chk_state("R7", 0, 0);
            read_all("R4");
        end

        // R9 underflow at cwp=1, swp=0
        pulse(0, 1, 0, 0);
        chk_state("R9", 0, 1);
        pulse(0, 0, 1, 0); chk_state("R10", 0, 1);
        pulse(1, 0, 0, 0); chk_state("R10", 0, 1);
        pulse(0, 0, 0, 1); mcwp = 0; mswp = 7;
        chk_state("R9", 0, 0);
        read_all("R9");

        // R11 simultaneous call and return
        pulse(1, 1, 0, 0);
        chk_state("R11", 0, 0);

        // R10 acknowledges with no trap pending
        pulse(0, 0, 1, 0); chk_state("R10", 0, 0);
        pulse(0, 0, 0, 1); chk_state("R10", 0, 0);

        // R9 underflow straight after reset-like state (cwp=0, swp=7)
        pulse(0, 1, 0, 0); chk_state("R9", 0, 1);
        pulse(0, 0, 0, 1); mcwp = 7; mswp = 6;
        chk_state("R9", 0, 0);
        pulse(1, 0, 0, 0); mcwp = 0;
        chk_state("R6", 0, 0);

        // R4 write in the same cycle as a call
        wr(11, 32'hCAFE_0003, 1'b1); mcwp = 1;
        chk_state("R4", 0, 0);
        ra_addr_i = 5'd27; #1;
        chk("R4", ra_data_o, 32'hCAFE_0003);
        read_all("R4");

        // R5 write not visible before the edge
        @(negedge clk);
        wr_en_i = 1; wr_addr_i = 5'd17; wr_data_i = 32'h1234_5678;
        ra_addr_i = 5'd17; #1;
        chk("R5", ra_data_o, model[phys(17, mcwp)]);
        model[phys(17, mcwp)] = 32'h1234_5678;
        @(negedge clk); wr_en_i = 0; #1;
        chk("R5", ra_data_o, 32'h1234_5678);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule